// File: doc/BRIEF.md
# DSP register file with MAC-register move unit

This block holds the working registers of a small DSP: six 32-bit data registers (two X-side, two Y-side, two multiplier-input registers), two 32-bit accumulators that each carry an 8-bit guard extension, an 8-bit condition/status register, and a pair of 32-bit multiply-accumulate result registers (high and low half). Besides holding results, the MAC pair is used as scratch storage. One local move copies a chosen data register or accumulator into either MAC half. The other local move copies either MAC half back into a chosen register.

Every 32-bit write into an accumulator also fills its guard field with copies of the written sign bit. Local moves leave the status register untouched. A separate parallel-move write port can load a register in the same cycle as a local move. When both target one register, the local move takes it and a conflict flag is raised. An observation read port returns any register, with its guard field when it is an accumulator.

Operand codes: 0 = X-side register a, 1 = X-side register b, 2 = Y-side register a, 3 = Y-side register b, 4 = multiplier register a, 5 = multiplier register b, 6 = accumulator 0, 7 = accumulator 1. Codes 8 to 15 are not operands. `op_dir` = 0 moves a register into a MAC half, and `op_dir` = 1 moves a MAC half into a register. `op_half` = 1 selects the high MAC half and 0 selects the low half.

Top module: `dsp_mac_move_rf`

## Requirements
- R1: A rising clock edge with `rst_n` low clears all eight registers, both guard fields, both MAC halves and the status register to zero.
- R2: With `op_valid`=1, `op_dir`=0 and a code 0..7, the selected register's 32-bit word is in the MAC half chosen by `op_half` after the next rising edge. The other MAC half and the source register are unchanged.
- R3: A move out of an accumulator (code 6 or 7) into a MAC half copies only its low 32 bits. The guard field is ignored.
- R4: With `op_valid`=1, `op_dir`=1 and a code 0..7, the MAC half chosen by `op_half` is in the selected register after the next rising edge.
- R5: Any write of a 32-bit value into accumulator 0 or 1, from a local move or from the parallel port, sets that accumulator's 8-bit guard field to eight copies of bit 31 of the value.
- R6: The status register changes only through `cond_we`/`cond_data`. No local move alters it, whatever value is moved.
- R7: With `op_valid`=1 and a code 8..15, `op_err` is 1 in that same cycle and no register, guard field or MAC half is written. `op_err` is 0 in all other cycles.
- R8: With `pm_we`=1 and `pm_sel` 0..7, `pm_data` is in that register after the next rising edge, even while a local move acts on another register. A `pm_sel` of 8..15 writes nothing.
- R9: When a register-bound local move (`op_dir`=1) and the parallel port name the same register in one cycle, the MAC value is written, and `conflict` is 1 during that cycle only.
- R10: `rd_data` follows `rd_sel` combinationally. Codes 0..5 return {8'h00, word}, codes 6 and 7 return {guard, word}, and codes 8..15 return zero.
- R11: A move into a MAC half captures the source register's value from before the edge, even if the parallel port writes that register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | A local move is presented this cycle |
| op_dir | input | 1 | 0: register to MAC half, 1: MAC half to register |
| op_sel | input | 4 | Operand code of the register side of the move |
| op_half | input | 1 | 1: high MAC half, 0: low MAC half |
| pm_we | input | 1 | Parallel-move write enable |
| pm_sel | input | 4 | Parallel-move target code |
| pm_data | input | 32 | Parallel-move write data |
| cond_we | input | 1 | Status register write enable (from the arithmetic side) |
| cond_data | input | 8 | Status register write data |
| rd_sel | input | 4 | Observation read code |
| rd_data | output | 40 | Observation read data |
| mac_hi_q | output | 32 | High MAC half |
| mac_lo_q | output | 32 | Low MAC half |
| cond_q | output | 8 | Status register |
| op_err | output | 1 | Illegal operand code on a presented move |
| conflict | output | 1 | Local move and parallel move hit the same register |

## Verification
The main sweep crosses all sixteen operand codes with both directions and both MAC halves, while the parallel port writes to a rotating target. Each step is compared against a full register model. This separates a wrong target decode from a wrong half select and a wrong direction, and it shows that legal moves leave unrelated registers alone.

Values with bit 31 set and with bit 31 clear are stored into each accumulator. This tells a guard field that tracks the sign apart from one that is stuck or copies the wrong bit. Reading an accumulator whose guard is all ones back into a MAC half shows that the guard is dropped.

Directed cases put the parallel port and a local move on the same register in both directions. These separate local-move priority from a plain read-before-write of the source. Reading every code after every step also catches stray writes and a status register that moves with local operations.

// File: rtl/dsp_mv_pkg.sv
// Shared constants and types for the DSP register file with MAC move unit.
// Assumes eight operand slots, with the two accumulators in the top two slots.
package dsp_mv_pkg;
    localparam int DSP_NREG     = 8;   // operand slots, codes 0..NREG-1
    localparam int DSP_ACC_BASE = 6;   // first accumulator slot
    localparam int DSP_NACC     = DSP_NREG - DSP_ACC_BASE;
    localparam int DSP_SELW     = 4;   // operand code width

    // direction of a local move
    typedef enum logic {
        MV_TO_MAC   = 1'b0,
        MV_FROM_MAC = 1'b1
    } mv_dir_e;
endpackage

// File: rtl/mv_decode.sv
// Decodes a local move and a parallel move into one-hot write enables.
// Assumes codes at or above NREG are not operands: a local move with such a
// code raises op_err and writes nothing, and a parallel move with one is dropped.
module mv_decode
    import dsp_mv_pkg::*;
#(
    parameter int NREG = DSP_NREG,
    parameter int SELW = DSP_SELW
) (
    input  logic            op_valid,
    input  logic            op_dir,
    input  logic [SELW-1:0] op_sel,
    input  logic            op_half,
    input  logic            pm_we,
    input  logic [SELW-1:0] pm_sel,
    output logic [NREG-1:0] loc_we,
    output logic [NREG-1:0] pm_we_vec,
    output logic            mac_hi_we,
    output logic            mac_lo_we,
    output logic            op_err,
    output logic            conflict
);
    localparam logic [SELW-1:0] LIMIT = SELW'(NREG);

    logic op_ok;
    logic is_store;
    logic is_load;

    // legality and direction of the presented local move
    always_comb begin
        op_ok    = op_sel < LIMIT;
        is_store = op_valid && op_ok && (mv_dir_e'(op_dir) == MV_FROM_MAC);
        is_load  = op_valid && op_ok && (mv_dir_e'(op_dir) == MV_TO_MAC);
    end

    // one comparator per slot for each write source
    for (genvar i = 0; i < NREG; i++) begin : g_slot
        assign loc_we[i]    = is_store && (op_sel == SELW'(i));
        assign pm_we_vec[i] = pm_we && (pm_sel == SELW'(i));
    end

    // MAC half enables, error pulse, same-target detection
    always_comb begin
        mac_hi_we = is_load && op_half;
        mac_lo_we = is_load && !op_half;
        op_err    = op_valid && !op_ok;
        conflict  = |(loc_we & pm_we_vec);
    end
endmodule

// File: rtl/mv_regbank.sv
// Storage: operand words, accumulator guard fields, MAC pair, status register.
// Assumes loc_we and pm_we_vec are one-hot or zero. A local write beats a
// parallel write to the same slot. Every accumulator write sign-extends into
// its guard field.
module mv_regbank
    import dsp_mv_pkg::*;
#(
    parameter int DW       = 32,
    parameter int GW       = 8,
    parameter int FW       = 8,
    parameter int NREG     = DSP_NREG,
    parameter int ACC_BASE = DSP_ACC_BASE,
    localparam int NACC    = NREG - ACC_BASE
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NREG-1:0]           loc_we,
    input  logic [DW-1:0]             loc_data,
    input  logic [NREG-1:0]           pm_we_vec,
    input  logic [DW-1:0]             pm_data,
    input  logic                      mac_hi_we,
    input  logic                      mac_lo_we,
    input  logic [DW-1:0]             mac_data,
    input  logic                      cond_we,
    input  logic [FW-1:0]             cond_data,
    output logic [NREG-1:0][DW-1:0]   dat_q,
    output logic [NACC-1:0][GW-1:0]   grd_q,
    output logic [DW-1:0]             mac_hi_q,
    output logic [DW-1:0]             mac_lo_q,
    output logic [FW-1:0]             cond_q
);
    // one word register per operand slot
    for (genvar i = 0; i < NREG; i++) begin : g_word
        logic [DW-1:0] word_r;
        // load the slot, local move first
        always_ff @(posedge clk) begin
            if (!rst_n)            word_r <= '0;
            else if (loc_we[i])    word_r <= loc_data;
            else if (pm_we_vec[i]) word_r <= pm_data;
        end
        assign dat_q[i] = word_r;
    end

    // guard field per accumulator slot, same priority as the word
    for (genvar g = 0; g < NACC; g++) begin : g_guard
        logic [GW-1:0] guard_r;
        // replicate the sign of whatever word is written
        always_ff @(posedge clk) begin
            if (!rst_n)                       guard_r <= '0;
            else if (loc_we[ACC_BASE+g])      guard_r <= {GW{loc_data[DW-1]}};
            else if (pm_we_vec[ACC_BASE+g])   guard_r <= {GW{pm_data[DW-1]}};
        end
        assign grd_q[g] = guard_r;

        // R5
        guard_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
            guard_r == {GW{dat_q[ACC_BASE+g][DW-1]}});
    end

    // MAC pair, written only by register-to-MAC moves
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mac_hi_q <= '0;
            mac_lo_q <= '0;
        end else begin
            if (mac_hi_we) mac_hi_q <= mac_data;
            if (mac_lo_we) mac_lo_q <= mac_data;
        end
    end

    // status register, owned by the arithmetic side only
    always_ff @(posedge clk) begin
        if (!rst_n)       cond_q <= '0;
        else if (cond_we) cond_q <= cond_data;
    end

    // R6
    cond_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cond_we |=> $stable(cond_q));
endmodule

// File: rtl/mv_readmux.sv
// Observation read port: picks one slot and widens it to word plus guard.
// Assumes the accumulators occupy slots ACC_BASE..NREG-1. Other slots read
// with a zero guard, and codes at or above NREG read as zero.
module mv_readmux
    import dsp_mv_pkg::*;
#(
    parameter int DW       = 32,
    parameter int GW       = 8,
    parameter int NREG     = DSP_NREG,
    parameter int ACC_BASE = DSP_ACC_BASE,
    parameter int SELW     = DSP_SELW,
    localparam int NACC    = NREG - ACC_BASE,
    localparam int IDXW    = $clog2(NREG)
) (
    input  logic [SELW-1:0]           rd_sel,
    input  logic [NREG-1:0][DW-1:0]   dat_q,
    input  logic [NACC-1:0][GW-1:0]   grd_q,
    output logic [GW+DW-1:0]          rd_data
);
    localparam logic [SELW-1:0] LIMIT = SELW'(NREG);

    logic [NREG-1:0][GW+DW-1:0] wide;

    // widen each slot, guard only on accumulators
    for (genvar i = 0; i < NREG; i++) begin : g_wide
        if (i >= ACC_BASE) begin : g_acc
            assign wide[i] = {grd_q[i-ACC_BASE], dat_q[i]};
        end else begin : g_dat
            assign wide[i] = {{GW{1'b0}}, dat_q[i]};
        end
    end

    // select the requested slot, zero for non-operand codes
    always_comb begin
        rd_data = '0;
        if (rd_sel < LIMIT) rd_data = wide[rd_sel[IDXW-1:0]];
    end
endmodule

// File: rtl/dsp_mac_move_rf.sv
// DSP register file with local moves between operands and the MAC pair.
// Assumes at most one local move and one parallel-move write per cycle.
// Writes land on the next rising edge, and the flags are combinational.
module dsp_mac_move_rf
    import dsp_mv_pkg::*;
#(
    parameter int DW       = 32,
    parameter int GW       = 8,
    parameter int FW       = 8,
    parameter int NREG     = DSP_NREG,
    parameter int ACC_BASE = DSP_ACC_BASE,
    parameter int SELW     = DSP_SELW,
    localparam int NACC    = NREG - ACC_BASE,
    localparam int IDXW    = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic             op_dir,
    input  logic [SELW-1:0]  op_sel,
    input  logic             op_half,
    input  logic             pm_we,
    input  logic [SELW-1:0]  pm_sel,
    input  logic [DW-1:0]    pm_data,
    input  logic             cond_we,
    input  logic [FW-1:0]    cond_data,
    input  logic [SELW-1:0]  rd_sel,
    output logic [GW+DW-1:0] rd_data,
    output logic [DW-1:0]    mac_hi_q,
    output logic [DW-1:0]    mac_lo_q,
    output logic [FW-1:0]    cond_q,
    output logic             op_err,
    output logic             conflict
);
    localparam logic [SELW-1:0] LIMIT = SELW'(NREG);

    logic [NREG-1:0]           loc_we;
    logic [NREG-1:0]           pm_we_vec;
    logic                      mac_hi_we;
    logic                      mac_lo_we;
    logic [NREG-1:0][DW-1:0]   dat_q;
    logic [NACC-1:0][GW-1:0]   grd_q;
    logic [DW-1:0]             mac_pick;
    logic [DW-1:0]             src_word;

    // operand side of each move: chosen MAC half and chosen low word
    always_comb begin
        mac_pick = op_half ? mac_hi_q : mac_lo_q;
        src_word = dat_q[op_sel[IDXW-1:0]];
    end

    mv_decode #(.NREG(NREG), .SELW(SELW)) u_decode (
        .op_valid (op_valid),
        .op_dir   (op_dir),
        .op_sel   (op_sel),
        .op_half  (op_half),
        .pm_we    (pm_we),
        .pm_sel   (pm_sel),
        .loc_we   (loc_we),
        .pm_we_vec(pm_we_vec),
        .mac_hi_we(mac_hi_we),
        .mac_lo_we(mac_lo_we),
        .op_err   (op_err),
        .conflict (conflict)
    );

    mv_regbank #(.DW(DW), .GW(GW), .FW(FW), .NREG(NREG), .ACC_BASE(ACC_BASE)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .loc_we   (loc_we),
        .loc_data (mac_pick),
        .pm_we_vec(pm_we_vec),
        .pm_data  (pm_data),
        .mac_hi_we(mac_hi_we),
        .mac_lo_we(mac_lo_we),
        .mac_data (src_word),
        .cond_we  (cond_we),
        .cond_data(cond_data),
        .dat_q    (dat_q),
        .grd_q    (grd_q),
        .mac_hi_q (mac_hi_q),
        .mac_lo_q (mac_lo_q),
        .cond_q   (cond_q)
    );

    mv_readmux #(.DW(DW), .GW(GW), .NREG(NREG), .ACC_BASE(ACC_BASE), .SELW(SELW)) u_rd (
        .rd_sel (rd_sel),
        .dat_q  (dat_q),
        .grd_q  (grd_q),
        .rd_data(rd_data)
    );

    // R2
    load_to_mac_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_dir && (op_sel < LIMIT)) |=>
        (($past(op_half) ? mac_hi_q : mac_lo_q) == $past(dat_q[op_sel[IDXW-1:0]])));

    // R4 (also covers R9: the local value is the one that lands)
    store_from_mac_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_dir && (op_sel < LIMIT)) |=>
        (dat_q[$past(op_sel[IDXW-1:0])] == $past(op_half ? mac_hi_q : mac_lo_q)));

    // R7
    bad_code_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !(op_sel < LIMIT)) |=> ($stable(mac_hi_q) && $stable(mac_lo_q)));

    // R8
    pm_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_we && (pm_sel < LIMIT) && !(op_valid && op_dir && (op_sel == pm_sel))) |=>
        (dat_q[$past(pm_sel[IDXW-1:0])] == $past(pm_data)));

    // R9
    conflict_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conflict |-> (op_valid && op_dir && pm_we && !op_err));
endmodule

// File: tb/dsp_mac_move_rf_bench.sv
`timescale 1ns/1ps
module dsp_mac_move_rf_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid, op_dir, op_half, pm_we, cond_we;
    logic [3:0]  op_sel, pm_sel, rd_sel;
    logic [31:0] pm_data;
    logic [7:0]  cond_data;
    logic [39:0] rd_data;
    logic [31:0] mac_hi_q, mac_lo_q;
    logic [7:0]  cond_q;
    logic        op_err, conflict;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] m_dat [8];
    logic [7:0]  m_grd [2];
    logic [31:0] m_hi, m_lo;
    logic [7:0]  m_cond;

    always #4 clk = ~clk;

    dsp_mac_move_rf u_dsp_mac_move_rf (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_dir(op_dir),
        .op_sel(op_sel), .op_half(op_half), .pm_we(pm_we), .pm_sel(pm_sel),
        .pm_data(pm_data), .cond_we(cond_we), .cond_data(cond_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .mac_hi_q(mac_hi_q),
        .mac_lo_q(mac_lo_q), .cond_q(cond_q), .op_err(op_err), .conflict(conflict)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(int k);
        return (32'(k) * 32'h9E37_79B9) ^ 32'h5A5A_0F0F;
    endfunction

    // model write: accumulators sign-extend into the guard (R5)
    task automatic mwr(logic [3:0] s, logic [31:0] v);
        m_dat[s[2:0]] = v;
        if (s == 4'd6 || s == 4'd7) m_grd[s[0]] = {8{v[31]}};
    endtask

    function automatic logic [39:0] exp_rd(logic [3:0] c);
        if (c < 4'd6) return {8'h00, m_dat[c[2:0]]};
        if (c < 4'd8) return {m_grd[c[0]], m_dat[c[2:0]]};
        return 40'h0;
    endfunction

    task automatic mclear();
        for (int i = 0; i < 8; i++) m_dat[i] = 32'h0;
        m_grd[0] = 8'h0; m_grd[1] = 8'h0;
        m_hi = 32'h0; m_lo = 32'h0; m_cond = 8'h0;
    endtask

    task automatic idle();
        op_valid = 1'b0; op_dir = 1'b0; op_sel = 4'd0; op_half = 1'b0;
        pm_we = 1'b0; pm_sel = 4'd0; pm_data = 32'h0;
        cond_we = 1'b0; cond_data = 8'h0;
    endtask

    // compare every read code, both MAC halves and the status register
    task automatic verify(string tag);
        for (int c = 0; c < 16; c++) begin
            rd_sel = 4'(c);
            #1;
            chk({tag, " R10"}, 64'(rd_data), 64'(exp_rd(4'(c))));
        end
        chk(tag, 64'(mac_hi_q), 64'(m_hi));
        chk(tag, 64'(mac_lo_q), 64'(m_lo));
        chk({tag, " R6"}, 64'(cond_q), 64'(m_cond));
    endtask

    // one operation cycle: drive, check flags, update the model, clock, verify
    task automatic step(string tag, bit v, bit d, logic [3:0] s, bit h,
                        bit pw, logic [3:0] ps, logic [31:0] pd, bit cw, logic [7:0] cd);
        bit ok, exp_err, exp_cf;
        logic [31:0] macv, srcv;
        @(negedge clk);
        op_valid = v; op_dir = d; op_sel = s; op_half = h;
        pm_we = pw; pm_sel = ps; pm_data = pd; cond_we = cw; cond_data = cd;
        ok      = v && (s < 4'd8);
        exp_err = v && (s >= 4'd8);
        exp_cf  = ok && d && pw && (ps == s);
        #2;
        chk({tag, " R7"}, 64'(op_err), 64'(exp_err));
        chk({tag, " R9"}, 64'(conflict), 64'(exp_cf));
        macv = h ? m_hi : m_lo;
        srcv = m_dat[s[2:0]];          // old value (R11, R3)
        if (pw && ps < 4'd8 && !(ok && d && ps == s)) mwr(ps, pd);
        if (ok && !d) begin
            if (h) m_hi = srcv; else m_lo = srcv;
        end
        if (ok && d) mwr(s, macv);
        if (cw) m_cond = cd;
        @(posedge clk);
        #1;
        idle();
        verify(tag);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run hung actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        idle();
        rd_sel = 4'd0;
        rst_n  = 1'b0;
        mclear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        verify("R1 reset");

        // R8 fill every slot through the parallel port
        for (int i = 0; i < 8; i++)
            step("R8 R5 fill", 1'b0, 1'b0, 4'd0, 1'b0, 1'b1, 4'(i), pat(i), 1'b0, 8'h00);
        step("R6 status", 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, 4'd0, 32'h0, 1'b1, 8'hA5);

        // sweep all codes x directions x halves with a concurrent parallel write
        for (int k = 0; k < 64; k++)
            step("R2 R3 R4 R5 R7 R8 sweep", 1'b1, k[4], 4'(k), k[5],
                 1'b1, 4'(k * 7 + 3), pat(k + 100), 1'b0, 8'h00);

        // R5 negative value into accumulator 1, positive into accumulator 0
        step("R5 prep", 1'b0, 1'b0, 4'd0, 1'b0, 1'b1, 4'd0, 32'h8000_0001, 1'b0, 8'h00);
        step("R2 hi", 1'b1, 1'b0, 4'd0, 1'b1, 1'b0, 4'd0, 32'h0, 1'b0, 8'h00);
        step("R5 neg", 1'b1, 1'b1, 4'd7, 1'b1, 1'b0, 4'd0, 32'h0, 1'b0, 8'h00);
        step("R5 prep", 1'b0, 1'b0, 4'd0, 1'b0, 1'b1, 4'd1, 32'h7FFF_FFFE, 1'b0, 8'h00);
        step("R2 lo", 1'b1, 1'b0, 4'd1, 1'b0, 1'b0, 4'd0, 32'h0, 1'b0, 8'h00);
        step("R5 pos", 1'b1, 1'b1, 4'd6, 1'b0, 1'b0, 4'd0, 32'h0, 1'b0, 8'h00);
        // R3 accumulator 1 has an all-ones guard; only the word reaches the MAC
        step("R3 acc", 1'b1, 1'b0, 4'd7, 1'b0, 1'b0, 4'd0, 32'h0, 1'b0, 8'h00);

        // R9 same target, local wins, in both accumulator and data slots
        step("R9 acc", 1'b1, 1'b1, 4'd6, 1'b1, 1'b1, 4'd6, 32'h1234_5678, 1'b0, 8'h00);
        step("R9 dat", 1'b1, 1'b1, 4'd2, 1'b0, 1'b1, 4'd2, 32'hFFFF_0000, 1'b0, 8'h00);
        // R11 move-to-MAC source rewritten by the parallel port in the same cycle
        step("R11", 1'b1, 1'b0, 4'd3, 1'b0, 1'b1, 4'd3, 32'hCAFE_F00D, 1'b0, 8'h00);
        // R8 parallel code out of range is dropped
        step("R8 bad", 1'b0, 1'b0, 4'd0, 1'b0, 1'b1, 4'd12, 32'hDEAD_BEEF, 1'b0, 8'h00);
        // R7 illegal local code with a status update in the same cycle
        step("R7 bad", 1'b1, 1'b1, 4'd9, 1'b1, 1'b0, 4'd0, 32'h0, 1'b1, 8'h3C);

        // R1 reset from a populated state
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        mclear();
        verify("R1 midrun");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule